// File: doc/BRIEF.md
# Row Buffer Burst Prefetch Serializer

This block is the column datapath of a narrow DRAM device. A row buffer holds one open row. Each column is `DQ_W` bits wide per chip, and there are `COLS` columns. A read names a column. The block drops the low address bits that choose a position inside a burst group and fetches the whole group of `BURST` adjacent columns in a single wide transfer. It then sends that group out one column per cycle, lowest column first. A write does the reverse. The block collects `BURST` beats and writes them into the group in one transfer, and only after the last beat has arrived.

`N_CHIPS` devices can sit side by side. They share one command and address path, and each has its own row buffer slice and its own `DQ_W`-bit lane. With the defaults scaled to eight chips of 8 bits and a burst of 8, one command moves 64 bytes. The row buffer is loaded one column at a time through a plain parallel port. Row activation and the storage array behind the row buffer lie outside this block.

Top module: `rbps_top`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `rd_data` are all zero. Reset does not clear the row buffer contents.
- R2: `rd_data` and `wr_data` are `DQ_W*N_CHIPS` bits wide. One command moves `BURST*DQ_W*N_CHIPS` bits, which is 64 bytes for 8 chips of 8 bits with a burst of 8. Chip `c` occupies lane bits `[c*DQ_W +: DQ_W]`.
- R3: A read accepted at a clock edge yields exactly `BURST` consecutive cycles with `rd_valid` high, starting on the next cycle. Beat k carries the column at group base + k, in ascending order.
- R4: The low `log2(BURST)` bits of `cmd_col` are ignored. Any column inside a group selects the same group, and its beats always start at offset 0.
- R5: `rd_data` is all zeros whenever `rd_valid` is low.
- R6: A command (`cmd_valid` high) is accepted only while `busy` is low. `busy` rises on the cycle after acceptance and falls after the last read beat, or after the write commit. Commands presented while `busy` is high are ignored.
- R7: After a write is accepted, each later cycle with `wr_valid` high captures `wr_data` as the next beat, offsets 0 to `BURST-1`. Idle cycles between beats are allowed. The group is written when the last beat is captured, and a read accepted afterwards returns the written beats.
- R8: An unfinished write burst, for example one cut short by reset, never changes the row buffer.
- R9: When `busy` is low, `load_en` writes `load_data` into column `load_col` of every chip. A load presented while `busy` is high is ignored.
- R10: `wr_valid` has no effect outside an accepted write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Row buffer column load strobe |
| load_col | input | CA_W | Column written by the load |
| load_data | input | DQ_W*N_CHIPS | Column data for all chips |
| cmd_valid | input | 1 | Column command request |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_col | input | CA_W | Column address; low bits ignored |
| wr_valid | input | 1 | Write beat strobe |
| wr_data | input | DQ_W*N_CHIPS | Write beat data |
| busy | output | 1 | A burst is in progress |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DQ_W*N_CHIPS | Read beat data |

## Verification
The bench builds the block with two chips, 64 columns and a burst of 8. This keeps a full row load down to 64 cycles, and it makes every group, including the top one at column 63, reachable within a short run. Using two chips means the per-chip lane placement and the per-chip row buffer slices are both exercised, not merely a single lane. The 64-byte-per-command width for eight chips is checked from the same width arithmetic.

// File: rtl/rbps_pkg.sv
package rbps_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/rbps_burst_ctrl.sv
module rbps_burst_ctrl
  import rbps_pkg::*;
#(
  parameter int CA_W  = 10,
  parameter int BURST = 8,
  localparam int OFS_W = $clog2(BURST),
  localparam int GRP_W = CA_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [CA_W-1:0]  cmd_col,
  input  logic             wr_valid,
  output logic             busy,
  output op_e              op,
  output logic [OFS_W-1:0] beat_idx,
  output logic             accept_rd,
  output logic             gather_en,
  output logic             commit,
  output logic [GRP_W-1:0] grp
);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(BURST - 1);

  op_e              op_q, op_d;
  logic [OFS_W-1:0] cnt_q, cnt_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic             step;
  logic             grp_en;

  always_comb begin
    op_d      = op_q;
    cnt_d     = cnt_q;
    grp_d     = grp_q;
    grp_en    = 1'b0;
    step      = 1'b0;
    accept_rd = 1'b0;
    gather_en = 1'b0;
    commit    = 1'b0;
    unique case (op_q)
      OP_IDLE: begin
        if (cmd_valid) begin
          op_d      = cmd_write ? OP_WRITE : OP_READ;
          cnt_d     = '0;
          grp_d     = cmd_col[CA_W-1:OFS_W];
          grp_en    = 1'b1;
          accept_rd = !cmd_write;
        end
      end
      OP_READ: step = 1'b1;
      OP_WRITE: begin
        step      = wr_valid;
        gather_en = wr_valid;
        commit    = wr_valid && (cnt_q == LAST);
      end
      default: op_d = OP_IDLE;
    endcase
    if (step) begin
      if (cnt_q == LAST) begin
        op_d  = OP_IDLE;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
      grp_q <= '0;
    end else begin
      op_q <= op_d;
      if (step || grp_en) cnt_q <= cnt_d;
      if (grp_en) grp_q <= grp_d;
    end
  end

  assign busy     = (op_q != OP_IDLE);
  assign op       = op_q;
  assign beat_idx = cnt_q;
  assign grp      = grp_q;

  // R6: a burst only ever starts from a presented command
  p_busy_from_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R6: the selected group holds for the whole burst
  p_grp_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(grp));
endmodule

// File: rtl/rbps_row_buffer.sv
module rbps_row_buffer #(
  parameter int N_CHIPS = 1,
  parameter int DQ_W    = 8,
  parameter int COLS    = 1024,
  parameter int BURST   = 8,
  localparam int CA_W   = $clog2(COLS),
  localparam int OFS_W  = $clog2(BURST),
  localparam int GRP_W  = CA_W - OFS_W,
  localparam int NGRP   = COLS / BURST,
  localparam int GW     = DQ_W * BURST,
  localparam int LANE_W = DQ_W * N_CHIPS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_en,
  input  logic [CA_W-1:0]                ld_col,
  input  logic [LANE_W-1:0]              ld_data,
  input  logic [GRP_W-1:0]               rd_grp,
  output logic [N_CHIPS-1:0][GW-1:0]     rd_word,
  input  logic                           wr_en,
  input  logic [GRP_W-1:0]               wr_grp,
  input  logic [N_CHIPS-1:0][GW-1:0]     wr_word
);
  logic [GRP_W-1:0] ld_grp;
  logic [OFS_W-1:0] ld_ofs;

  assign ld_grp = ld_col[CA_W-1:OFS_W];
  assign ld_ofs = ld_col[OFS_W-1:0];

  for (genvar c = 0; c < N_CHIPS; c++) begin : g_chip
    logic [GW-1:0] store [NGRP];

    always_ff @(posedge clk) begin
      if (wr_en) begin
        store[wr_grp] <= wr_word[c];
      end else if (ld_en) begin
        store[ld_grp][ld_ofs*DQ_W +: DQ_W] <= ld_data[c*DQ_W +: DQ_W];
      end
    end

    assign rd_word[c] = store[rd_grp];
  end

  // R9: column loads and group commits never collide
  p_no_port_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && ld_en));
endmodule

// File: rtl/rbps_lane_serdes.sv
module rbps_lane_serdes #(
  parameter int LANE_W = 8,
  parameter int BURST  = 8,
  localparam int OFS_W = $clog2(BURST)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_pf,
  input  logic [BURST-1:0][LANE_W-1:0] pf_in,
  input  logic                         shift,
  input  logic                         rd_valid,
  output logic [LANE_W-1:0]            rd_data,
  input  logic                         gather_en,
  input  logic [OFS_W-1:0]             beat_idx,
  input  logic [LANE_W-1:0]            wr_data,
  output logic [BURST-1:0][LANE_W-1:0] commit_word
);
  logic [BURST-1:0][LANE_W-1:0] pf_q, pf_d;
  logic [BURST-1:0][LANE_W-1:0] gth_q, gth_d;
  logic                         pf_en;

  always_comb begin
    pf_en = load_pf || shift;
    pf_d  = pf_q;
    if (load_pf) begin
      pf_d = pf_in;
    end else if (shift) begin
      for (int i = 0; i < BURST - 1; i++) pf_d[i] = pf_q[i+1];
      pf_d[BURST-1] = '0;
    end
  end

  always_comb begin
    gth_d = gth_q;
    gth_d[beat_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q  <= '0;
      gth_q <= '0;
    end else begin
      if (pf_en) pf_q <= pf_d;
      if (gather_en) gth_q <= gth_d;
    end
  end

  assign rd_data     = rd_valid ? pf_q[0] : '0;
  assign commit_word = gth_d;

  // R3: each following beat is the next prefetched column
  p_beat_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && !$past(load_pf)) |-> (rd_data == $past(pf_q[1])));
endmodule

// File: rtl/rbps_top.sv
module rbps_top
  import rbps_pkg::*;
#(
  parameter int N_CHIPS = 1,
  parameter int DQ_W    = 8,
  parameter int COLS    = 1024,
  parameter int BURST   = 8,
  localparam int CA_W   = $clog2(COLS),
  localparam int LANE_W = DQ_W * N_CHIPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CA_W-1:0]   load_col,
  input  logic [LANE_W-1:0] load_data,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [CA_W-1:0]   cmd_col,
  input  logic              wr_valid,
  input  logic [LANE_W-1:0] wr_data,
  output logic              busy,
  output logic              rd_valid,
  output logic [LANE_W-1:0] rd_data
);
  localparam int OFS_W       = $clog2(BURST);
  localparam int GRP_W       = CA_W - OFS_W;
  localparam int GW          = DQ_W * BURST;
  localparam int CMD_BYTES   = (GW * N_CHIPS) / 8;
  localparam int RUN_W       = OFS_W + 2;

  op_e                          op;
  logic [OFS_W-1:0]             beat_idx;
  logic                         accept_rd, gather_en, commit;
  logic [GRP_W-1:0]             grp;
  logic                         ld_ok;
  logic [N_CHIPS-1:0][GW-1:0]   rb_rd_word, rb_wr_word;
  logic [BURST-1:0][LANE_W-1:0] pf_in, commit_word;

  rbps_burst_ctrl #(.CA_W(CA_W), .BURST(BURST)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .wr_valid(wr_valid),
    .busy(busy), .op(op), .beat_idx(beat_idx),
    .accept_rd(accept_rd), .gather_en(gather_en), .commit(commit), .grp(grp)
  );

  assign ld_ok = load_en && !busy;

  rbps_row_buffer #(.N_CHIPS(N_CHIPS), .DQ_W(DQ_W), .COLS(COLS), .BURST(BURST)) i_rowbuf (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_ok), .ld_col(load_col), .ld_data(load_data),
    .rd_grp(cmd_col[CA_W-1:OFS_W]), .rd_word(rb_rd_word),
    .wr_en(commit), .wr_grp(grp), .wr_word(rb_wr_word)
  );

  // lane c of beat b <-> byte b of chip c's group word
  for (genvar c = 0; c < N_CHIPS; c++) begin : g_map_chip
    for (genvar b = 0; b < BURST; b++) begin : g_map_beat
      assign pf_in[b][c*DQ_W +: DQ_W]      = rb_rd_word[c][b*DQ_W +: DQ_W];
      assign rb_wr_word[c][b*DQ_W +: DQ_W] = commit_word[b][c*DQ_W +: DQ_W];
    end
  end

  assign rd_valid = (op == OP_READ);

  rbps_lane_serdes #(.LANE_W(LANE_W), .BURST(BURST)) i_serdes (
    .clk(clk), .rst_n(rst_n),
    .load_pf(accept_rd), .pf_in(pf_in),
    .shift(rd_valid), .rd_valid(rd_valid), .rd_data(rd_data),
    .gather_en(gather_en), .beat_idx(beat_idx), .wr_data(wr_data),
    .commit_word(commit_word)
  );

  // ---- checks ----
  initial begin
    p_cmd_bytes_r2: assert (CMD_BYTES * 8 == BURST * DQ_W * N_CHIPS);
  end

  logic [RUN_W-1:0] rv_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_run_q <= '0;
    else        rv_run_q <= rd_valid ? rv_run_q + 1'b1 : '0;
  end

  // R3: every read burst is exactly BURST beats long
  p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> (rv_run_q == RUN_W'(BURST)));

  // R6: read beats only while a burst is in progress
  p_rdvalid_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  // R7: a write burst never turns into read beats
  p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_valid) |=> !rd_valid);

  // R5: idle output is zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> (rd_data == '0));
endmodule

// File: tb/test_rbps_top.sv
module test_rbps_top;
  localparam int NC   = 2;
  localparam int DQ   = 8;
  localparam int COLS = 64;
  localparam int BL   = 8;
  localparam int CAW  = 6;
  localparam int LW   = DQ * NC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_en, cmd_valid, cmd_write, wr_valid;
  logic [CAW-1:0] load_col, cmd_col;
  logic [LW-1:0]  load_data, wr_data;
  logic          busy, rd_valid;
  logic [LW-1:0]  rd_data;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  rbps_top #(.N_CHIPS(NC), .DQ_W(DQ), .COLS(COLS), .BURST(BL)) i_rbps_top (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .load_col(load_col), .load_data(load_data),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---- behavioural reference model ----
  logic [LW-1:0] ref_col [COLS];
  bit            m_busy, m_wr;
  int            m_cnt, m_grp;
  logic [LW-1:0] m_q [$];
  logic [LW-1:0] m_gath [BL];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_cnt = 0; m_q.delete();
    end else if (!m_busy) begin
      if (cmd_valid) begin
        m_grp  = int'(cmd_col) / BL;
        m_busy = 1;
        m_wr   = cmd_write;
        m_cnt  = 0;
        if (!cmd_write)
          for (int k = 0; k < BL; k++) m_q.push_back(ref_col[m_grp*BL + k]);
      end
      if (load_en) ref_col[load_col] = load_data;
    end else if (m_wr) begin
      if (wr_valid) begin
        m_gath[m_cnt] = wr_data;
        m_cnt++;
        if (m_cnt == BL) begin
          for (int k = 0; k < BL; k++) ref_col[m_grp*BL + k] = m_gath[k];
          m_busy = 0;
        end
      end
    end else begin
      void'(m_q.pop_front());
      if (m_q.size() == 0) m_busy = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      logic          erv;
      logic [LW-1:0] erd;
      erv = m_busy && !m_wr;
      erd = erv ? m_q[0] : '0;
      chk("R6 busy", 64'(busy), 64'(m_busy));
      chk("R3 rd_valid", 64'(rd_valid), 64'(erv));
      chk("R5 rd_data", 64'(rd_data), 64'(erd));
    end
  end

  // ---- stimulus helpers (drive at negedge) ----
  task automatic idle_inputs();
    load_en = 0; cmd_valid = 0; cmd_write = 0; wr_valid = 0;
    load_col = '0; load_data = '0; cmd_col = '0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic load_col_t(input int col, input logic [LW-1:0] d);
    load_en = 1; load_col = CAW'(col); load_data = d;
    @(negedge clk);
    load_en = 0;
  endtask

  // issues a read and checks every beat against expectations taken now
  task automatic read_check(input int col, input string tag);
    logic [LW-1:0] exp [BL];
    int g;
    g = col / BL;
    for (int k = 0; k < BL; k++) exp[k] = ref_col[g*BL + k];
    cmd_valid = 1; cmd_write = 0; cmd_col = CAW'(col);
    @(negedge clk);
    cmd_valid = 0;
    for (int k = 0; k < BL; k++) begin
      chk($sformatf("%s beat%0d", tag, k), 64'(rd_data), 64'(exp[k]));
      @(negedge clk);
    end
  endtask

  task automatic write_burst(input int col, input logic [LW-1:0] b [BL], input bit gaps);
    cmd_valid = 1; cmd_write = 1; cmd_col = CAW'(col);
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
    for (int k = 0; k < BL; k++) begin
      if (gaps && (k % 3 == 1)) begin
        wr_valid = 0; wr_data = 16'hDEAD;
        @(negedge clk);
      end
      wr_valid = 1; wr_data = b[k];
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  function automatic logic [LW-1:0] pat(input int col);
    return {8'(col * 13 + 7), 8'(col * 5 + 1)};
  endfunction

  initial begin
    logic [LW-1:0] wb [BL];
    idle_inputs();
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    chk("R1 rd_data", 64'(rd_data), 64'd0);
    // R2 width: lane is DQ*NC bits, 8 chips x 8 bits x burst 8 = 64 bytes
    chk("R2 lane width", 64'($bits(rd_data)), 64'(DQ * NC));
    chk("R2 bytes per command", 64'($bits(rd_data) * BL / 8), 64'(NC * DQ));
    chk("R2 eight-chip bytes", 64'(8 * DQ * BL / 8), 64'd64);
    cmp_on = 1;

    // R9 loads while idle
    for (int c = 0; c < COLS; c++) load_col_t(c, pat(c));

    // R3 ascending beats from an aligned column
    read_check(0, "R3 grp0");
    read_check(16, "R3 grp2");
    // R4 low bits ignored
    read_check(3 * BL + 5, "R4 col29");
    read_check(COLS - 1, "R4 col63");

    // R6 command during burst is ignored
    cmd_valid = 1; cmd_write = 0; cmd_col = 6'd8;
    @(negedge clk);
    cmd_write = 1; cmd_col = 6'd40;
    repeat (4) @(negedge clk);
    cmd_valid = 0;
    repeat (5) @(negedge clk);
    chk("R6 idle after burst", 64'(busy), 64'd0);
    read_check(40, "R6 grp5 untouched");

    // R9 load while busy is ignored
    cmd_valid = 1; cmd_write = 0; cmd_col = 6'd0;
    @(negedge clk);
    cmd_valid = 0;
    load_en = 1; load_col = 6'd10; load_data = 16'hBEEF;
    @(negedge clk);
    load_en = 0;
    repeat (8) @(negedge clk);
    read_check(10, "R9 busy load ignored");
    chk("R9 model col10", 64'(ref_col[10]), 64'(pat(10)));

    // R10 stray write beats while idle
    wr_valid = 1; wr_data = 16'h5555;
    repeat (3) @(negedge clk);
    wr_valid = 0;
    // R7 write with gaps then read back
    for (int k = 0; k < BL; k++) wb[k] = 16'h1100 + 16'(k * 17);
    write_burst(2 * BL + 3, wb, 1'b1);
    chk("R7 idle after commit", 64'(busy), 64'd0);
    read_check(2 * BL, "R7 readback");
    chk("R10 beat0 not stray", 64'(ref_col[2 * BL]), 64'(16'h1100));
    // R7 write without gaps, read issued the cycle busy falls
    for (int k = 0; k < BL; k++) wb[k] = 16'hA000 ^ 16'(k * 257);
    write_burst(4 * BL, wb, 1'b0);
    read_check(4 * BL + 7, "R7 back-to-back");

    // R8 partial write cut by reset leaves group unchanged
    for (int k = 0; k < BL; k++) wb[k] = 16'hFFFF;
    cmd_valid = 1; cmd_write = 1; cmd_col = 6'd48;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
    wr_valid = 1; wr_data = 16'hFFFF;
    repeat (5) @(negedge clk);
    wr_valid = 0;
    cmp_on = 0;
    do_reset();
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
    cmp_on = 1;
    read_check(48, "R8 partial write no effect");
    read_check(0, "R1 contents kept");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule